// File: doc/BRIEF.md
# Precomputed-Candidate Decision Feedback Filter

This block is the decision-feedback half of a binary-symbol equalizer. The usual feedback filter multiplies each stored past decision by its tap weight and adds the products. Here a two-level symbol makes every product either +w or -w. For a filter with TAPS taps, the block builds all 2^TAPS signed weight sums in advance and keeps them in a register bank. That bank is rewritten only when a weight-load strobe is raised.

Each incoming feedforward sample is added to every candidate sum in one pipeline stage. The recursive step then only selects one of those precomputed results. It uses a binary tree of 2-to-1 multiplexers steered by the last TAPS decisions. So the loop from one decision to the next passes through multiplexers alone, with no adder, comparator or multiplier. The selected soft value and its sign-derived decision are registered as outputs. A flag marks the decisions that were made before the history held TAPS real decisions.

Top module: `dfe_precomp_fbf`

## Requirements
- R1: After reset, `dec_vld`, `dec_o` and `hist_ok` are 0, every candidate sum is 0, and the decision history is all zeros. The first decision after reset therefore treats every past symbol as -1.
- R2: A decision is 1 exactly when its soft value is zero or positive and 0 when the value is negative. A soft value of exactly 0 gives 1.
- R3: The soft value is the sample plus, for every tap t (0 ≤ t < TAPS), +w_t if the decision made t+1 valid samples earlier was 1 and -w_t if it was 0. Tap t occupies `wt_i[t*WW +: WW]` as two's complement.
- R4: A sample accepted with `smp_vld` at one rising edge produces exactly one output with `dec_vld` high after the second rising edge. Edges without a sample produce no output.
- R5: Weights take effect only at an edge where `wt_load` is 1. Changing `wt_i` without the strobe has no effect on any output. A sample accepted at the same edge as a load still uses the previous weights.
- R6: The decision history advances only on valid samples. Idle cycles between samples leave it unchanged.
- R7: `hist_ok` is 0 on the first TAPS outputs after reset and 1 on every output after that. It is never 1 while `dec_vld` is 0.
- R8: Candidate sums are WW + ceil(log2(TAPS+1)) bits wide and soft values are one bit wider than the wider of sample and candidate. Full-scale weights and samples never wrap.
- R9: Samples may arrive on consecutive cycles. Each decision then steers the selection for the very next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_load | input | 1 | Strobe that captures `wt_i` and rebuilds the candidate bank |
| wt_i | input | TAPS*WW | Tap weights, tap t at bits [t*WW +: WW], two's complement |
| smp_vld | input | 1 | Qualifies `smp_i` |
| smp_i | input | SMP_W | Feedforward filter output, two's complement |
| dec_vld | output | 1 | Output qualifier |
| dec_o | output | 1 | Slicer decision, 1 for +1 and 0 for -1 |
| soft_o | output | max(SMP_W, WW+ceil(log2(TAPS+1)))+1 | Corrected soft value, two's complement |
| hist_ok | output | 1 | Decision was made with a fully populated history |

## Verification
The bench aims at the corners where a slip in the selection or the update would stay hidden by average data.

A soft value of exactly zero must slice to 1. A reversed tap-to-bit order in the multiplexer steering would give wrong soft values once the history holds mixed decisions. Back-to-back samples expose a history that updates one cycle late, because each decision must steer the very next sample. Idle gaps expose a history that shifts on empty cycles.

Weights changed without the strobe, and a load landing on the same edge as a sample, catch a bank that follows `wt_i` directly. All-extreme weights and full-scale samples catch a sum that wraps. The warm-up flag is checked across its TAPS-th and next output.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
   // width of one precomputed weight sum over taps entries of ww bits
   function automatic int cand_width(input int ww, input int taps);
      return ww + $clog2(taps + 1);
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dfe_cand_bank.sv
module dfe_cand_bank #(
   parameter int TAPS = 3,
   parameter int WW   = 8,
   parameter int CW   = dfe_pkg::cand_width(WW, TAPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [TAPS*WW-1:0]   wt_i,
   output logic [CW-1:0]        cand_o [1<<TAPS]
);
   localparam int N = 1 << TAPS;

   logic [CW-1:0] cand_nxt [N];

   // every signed combination: bit t of the index picks +w_t (1) or -w_t (0)
   always_comb begin
      for (int k = 0; k < N; k++) begin
         logic signed [CW-1:0] acc;
         acc = '0;
         for (int t = 0; t < TAPS; t++) begin
            logic signed [CW-1:0] wx;
            wx = signed'({{(CW-WW){wt_i[t*WW+WW-1]}}, wt_i[t*WW +: WW]});
            acc = k[t] ? (acc + wx) : (acc - wx);
         end
         cand_nxt[k] = acc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) cand_o[k] <= '0;
      end else if (load) begin
         for (int k = 0; k < N; k++) cand_o[k] <= cand_nxt[k];
      end
   end

   // R5: the bank only moves on a load strobe
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(cand_o[0]) && $stable(cand_o[N-1])));

   // R3: the all-plus and all-minus candidates are negatives of each other
   p_cand_sym_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(cand_o[N-1]) == -$signed(cand_o[0]));
endmodule

// File: rtl/dfe_mux_tree.sv
module dfe_mux_tree #(
   parameter int W    = 8,
   parameter int SELW = 3
) (
   input  logic [W-1:0]    leaf_i [1<<SELW],
   input  logic [SELW-1:0] sel_i,
   output logic [W-1:0]    out_o
);
   localparam int N = 1 << SELW;

   // heap layout: node i has children 2i+1 (select bit 0) and 2i+2 (select bit 1)
   logic [W-1:0] node [2*N-1];

   for (genvar k = 0; k < N; k++) begin : g_leaf
      assign node[N-1+k] = leaf_i[k];
   end

   for (genvar d = 0; d < SELW; d++) begin : g_lvl
      for (genvar j = 0; j < (1 << d); j++) begin : g_node
         localparam int I = (1 << d) - 1 + j;
         assign node[I] = sel_i[SELW-1-d] ? node[2*I+2] : node[2*I+1];
      end
   end

   assign out_o = node[0];
endmodule

// File: rtl/dfe_precomp_fbf.sv
module dfe_precomp_fbf #(
   parameter int TAPS  = 3,
   parameter int WW    = 8,
   parameter int SMP_W = 10,
   localparam int CW     = dfe_pkg::cand_width(WW, TAPS),
   localparam int SOFT_W = dfe_pkg::max_int(SMP_W, CW) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wt_load,
   input  logic [TAPS*WW-1:0]  wt_i,
   input  logic                smp_vld,
   input  logic [SMP_W-1:0]    smp_i,
   output logic                dec_vld,
   output logic                dec_o,
   output logic [SOFT_W-1:0]   soft_o,
   output logic                hist_ok
);
   localparam int N     = 1 << TAPS;
   localparam int CNT_W = $clog2(TAPS + 1);

   if (TAPS < 1 || TAPS > 8) begin : g_bad_taps
      $error("TAPS out of supported range 1..8");
   end
   if (WW < 2 || SMP_W < 2) begin : g_bad_width
      $error("weight and sample widths must be at least 2");
   end

   logic [CW-1:0]     cand [N];
   logic [SOFT_W-1:0] ycand [N];
   logic [0:0]        dbit [N];
   logic              stg_vld;
   logic [TAPS-1:0]   hist;
   logic [CNT_W-1:0]  fill;
   logic [0:0]        dec_nxt;
   logic [SOFT_W-1:0] soft_nxt;

   dfe_cand_bank #(.TAPS(TAPS), .WW(WW), .CW(CW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wt_load),
      .wt_i   (wt_i),
      .cand_o (cand)
   );

   // stage 1: sample plus every candidate, outside the decision loop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld <= 1'b0;
         for (int k = 0; k < N; k++) ycand[k] <= '0;
      end else begin
         stg_vld <= smp_vld;
         if (smp_vld) begin
            for (int k = 0; k < N; k++) begin
               ycand[k] <= SOFT_W'(signed'({{(SOFT_W-SMP_W){smp_i[SMP_W-1]}}, smp_i})
                          + signed'({{(SOFT_W-CW){cand[k][CW-1]}}, cand[k]}));
            end
         end
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_slice
      assign dbit[k] = ~ycand[k][SOFT_W-1];
   end

   // the recursion: history -> multiplexer tree -> history
   dfe_mux_tree #(.W(1), .SELW(TAPS)) u_dec_mux (
      .leaf_i (dbit),
      .sel_i  (hist),
      .out_o  (dec_nxt)
   );

   dfe_mux_tree #(.W(SOFT_W), .SELW(TAPS)) u_soft_mux (
      .leaf_i (ycand),
      .sel_i  (hist),
      .out_o  (soft_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist    <= '0;
         fill    <= '0;
         dec_vld <= 1'b0;
         dec_o   <= 1'b0;
         soft_o  <= '0;
         hist_ok <= 1'b0;
      end else begin
         dec_vld <= stg_vld;
         hist_ok <= stg_vld && (fill == CNT_W'(TAPS));
         if (stg_vld) begin
            dec_o  <= dec_nxt[0];
            soft_o <= soft_nxt;
            hist   <= TAPS'({hist, dec_nxt[0]});
            if (fill != CNT_W'(TAPS)) fill <= fill + 1'b1;
         end
      end
   end

   // R2: decision and soft value leave through separate trees and must agree
   p_dec_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> (dec_o == ~soft_o[SOFT_W-1]));

   // R7: the warm-up flag only accompanies a real output
   p_ok_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok |-> dec_vld);

   // R4: two-edge latency from an accepted sample to its output
   p_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> ##1 dec_vld);

   // R4: an idle input slot yields no output
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ##1 !dec_vld);
endmodule

// File: tb/test_dfe_precomp_fbf.sv
module test_dfe_precomp_fbf;
   localparam int TAPS   = 3;
   localparam int WW     = 8;
   localparam int SMP_W  = 10;
   localparam int SOFT_W = 11;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                wt_load = 1'b0;
   logic [TAPS*WW-1:0]  wt_i = '0;
   logic                smp_vld = 1'b0;
   logic [SMP_W-1:0]    smp_i = '0;
   logic                dec_vld;
   logic                dec_o;
   logic [SOFT_W-1:0]   soft_o;
   logic                hist_ok;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string tag   = "R1";

   // reference state
   logic [TAPS-1:0]    m_hist = '0;
   int                 m_fill = 0;
   logic [TAPS*WW-1:0] m_w = '0;
   bit                 p1_vld = 1'b0;
   int                 p1_x = 0;
   logic [TAPS*WW-1:0] p1_w = '0;

   always #2 clk = ~clk;

   dfe_precomp_fbf #(.TAPS(TAPS), .WW(WW), .SMP_W(SMP_W)) i_dfe_precomp_fbf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wt_load (wt_load),
      .wt_i    (wt_i),
      .smp_vld (smp_vld),
      .smp_i   (smp_i),
      .dec_vld (dec_vld),
      .dec_o   (dec_o),
      .soft_o  (soft_o),
      .hist_ok (hist_ok)
   );

   task automatic chk(input bit good, input string rq, input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", rq, tag, act, exp, $time);
      end
   endtask

   // per-edge reference: check what the design shows, then record this edge's input
   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         m_hist = '0; m_fill = 0; m_w = '0; p1_vld = 1'b0;
      end else begin
         if (p1_vld) begin
            int y;
            bit d;
            bit ok;
            y = p1_x;
            for (int t = 0; t < TAPS; t++) begin
               int w;
               w = $signed(p1_w[t*WW +: WW]);
               y = m_hist[t] ? y + w : y - w;
            end
            d  = (y >= 0);
            ok = (m_fill >= TAPS);
            chk(dec_vld == 1'b1, "R4", int'(dec_vld), 1);
            chk($signed(soft_o) == y, "R3", $signed(soft_o), y);
            chk(dec_o == d, "R2", int'(dec_o), int'(d));
            chk(hist_ok == ok, "R7", int'(hist_ok), int'(ok));
            m_hist = TAPS'({m_hist, d});
            m_fill++;
         end else begin
            chk(dec_vld == 1'b0, "R4", int'(dec_vld), 0);
            chk(hist_ok == 1'b0, "R7", int'(hist_ok), 0);
         end
         p1_vld = smp_vld;
         p1_x   = $signed(smp_i);
         p1_w   = m_w;
         if (wt_load) m_w = wt_i;
      end
   end

   task automatic step(input bit v, input int x, input bit ld, input logic [TAPS*WW-1:0] w);
      @(negedge clk);
      smp_vld = v;
      smp_i   = x[SMP_W-1:0];
      wt_load = ld;
      wt_i    = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, wt_i);
   endtask

   function automatic logic [TAPS*WW-1:0] pack_w(input int w0, input int w1, input int w2);
      return {w2[WW-1:0], w1[WW-1:0], w0[WW-1:0]};
   endfunction

   task automatic do_reset();
      tag = "R1";
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dec_vld == 1'b0, "R1", int'(dec_vld), 0);
      chk(dec_o == 1'b0, "R1", int'(dec_o), 0);
      chk(hist_ok == 1'b0, "R1", int'(hist_ok), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_first_after_reset();
      // weights 0 after reset: soft equals the sample; history all -1
      tag = "R1";
      step(1'b1, -5, 1'b0, wt_i);
      step(1'b1, 7, 1'b0, wt_i);
      idle(3);
      tag = "R1";
      step(1'b0, 0, 1'b1, pack_w(10, 20, 40));
      step(1'b1, 0, 1'b0, wt_i);
      idle(3);
   endtask

   task automatic t_zero_and_signs();
      do_reset();
      tag = "R2";
      step(1'b0, 0, 1'b1, pack_w(10, 20, 40));
      idle(1);
      // history 000: feedback -70; x=70 gives exactly zero, so decision 1
      step(1'b1, 70, 1'b0, wt_i);
      idle(2);
      step(1'b1, -1, 1'b0, wt_i);
      idle(2);
      step(1'b1, 200, 1'b0, wt_i);
      idle(3);
   endtask

   task automatic t_tap_order();
      tag = "R3";
      step(1'b0, 0, 1'b1, pack_w(3, -50, 100));
      idle(1);
      for (int i = 0; i < 10; i++) begin
         step(1'b1, (i % 3 == 0) ? 150 : -150 + i, 1'b0, wt_i);
         idle(1);
      end
      idle(3);
   endtask

   task automatic t_back_to_back();
      tag = "R9";
      step(1'b0, 0, 1'b1, pack_w(60, -30, 15));
      for (int i = 0; i < 24; i++) step(1'b1, ((i * 37) % 181) - 90, 1'b0, wt_i);
      idle(3);
   endtask

   task automatic t_gaps();
      tag = "R6";
      for (int i = 0; i < 12; i++) begin
         step(1'b1, (i % 2) ? 40 : -45, 1'b0, wt_i);
         idle(i % 4);
      end
      idle(3);
   endtask

   task automatic t_weight_hold();
      tag = "R5";
      step(1'b0, 0, 1'b1, pack_w(25, 25, 25));
      // new weights presented without the strobe must be ignored
      step(1'b1, 10, 1'b0, pack_w(-100, 90, -80));
      for (int i = 0; i < 8; i++) step(1'b1, 20 - 7 * i, 1'b0, wt_i);
      idle(3);
      // a sample on the load edge still sees the old weights
      step(1'b1, 30, 1'b1, pack_w(-100, 90, -80));
      step(1'b1, 30, 1'b0, wt_i);
      step(1'b1, -30, 1'b0, wt_i);
      idle(3);
   endtask

   task automatic t_warmup();
      do_reset();
      tag = "R7";
      step(1'b0, 0, 1'b1, pack_w(5, 5, 5));
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 100 - 40 * i, 1'b0, wt_i);
         idle(i % 2);
      end
      idle(3);
   endtask

   task automatic t_extremes();
      tag = "R8";
      step(1'b0, 0, 1'b1, pack_w(-128, -128, -128));
      for (int i = 0; i < 5; i++) step(1'b1, 511, 1'b0, wt_i);
      for (int i = 0; i < 5; i++) step(1'b1, -512, 1'b0, wt_i);
      step(1'b0, 0, 1'b1, pack_w(127, 127, 127));
      for (int i = 0; i < 5; i++) step(1'b1, -512, 1'b0, wt_i);
      for (int i = 0; i < 5; i++) step(1'b1, 511, 1'b0, wt_i);
      idle(3);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 20000, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_first_after_reset();
      t_zero_and_signs();
      t_tap_order();
      t_back_to_back();
      t_gaps();
      t_weight_hold();
      t_warmup();
      t_extremes();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule